// File: doc/BRIEF.md
# Multi-Channel SAR ADC Sample Reader

This block is an SPI master that takes one sample from a successive-approximation ADC. Parameters choose the converter variant: one, two, four or eight inputs, and 10, 12 or 13 bits of resolution. A request pulse carries a channel number and a differential flag. The block then pulls chip select low and, on multi-input variants, shifts out a command byte. It clocks in the response bytes and releases chip select. Finally it extracts the converted value from the received word and presents it with a one-cycle completion pulse.

The serial clock idles low. MOSI is updated only while SCLK is low, and MISO is sampled on the rising SCLK edge, most significant bit first. SCLK runs at the system clock divided by 2·HALF. Single-input variants have no data input on the converter, so they only receive. The 13-bit variant delivers a two's-complement value that is sign-extended to the output width. All other variants deliver an unsigned value, zero-extended. A channel number outside the selected variant's range does not start a transfer; it produces an error pulse instead.

Top module: `sar_adc_reader`

## Requirements
- R1: After reset: spi_cs_n=1, spi_sclk=0, spi_mosi=0, busy=0, done=0, err=0, rd_data=0.
- R2: SCLK is low whenever CS is high. MOSI changes only while SCLK is low. MISO is taken on SCLK rising edges, MSB first.
- R3: Each transaction keeps CS low for exactly TX+RX rising SCLK edges. TX is 8 on multi-input variants and 0 on single-input ones. RX is 8 times ceil(RES/8).
- R4: Two-input variant command byte: bit 4 = 1 (start), bit 3 = NOT differential, bit 2 = channel, all other bits 0.
- R5: Four- and eight-input variant command byte: bit 6 = 1 (start), bit 5 = NOT differential, channel in bits 4:2, all other bits 0.
- R6: Single-input variants send no command. MOSI stays 0. The differential flag has no effect, since the only input is the 0-to-1 pair.
- R7: Let W be the received word, first byte in W[15:8]. Multi-input variants return W[15:16-RES]. Single-input variants return W[12:13-RES]. Unsigned results are zero-extended.
- R8: The 13-bit variant returns W[12:0] as two's complement (bit 12 = sign), sign-extended to OUT_W bits.
- R9: busy rises the cycle after an accepted request and falls in the cycle where done pulses for one cycle. rd_data is valid from that cycle on. CS is low only while busy.
- R10: A request while busy is ignored. It changes neither the running frame, the command sent nor the result, and it starts no further frame.
- R11: A channel number not below NUM_CH gives a one-cycle err pulse the cycle after the request. There is no CS activity and busy stays low.
- R12: CS stays high for at least 2·HALF system cycles (one SCLK period) between transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start request, one-cycle pulse |
| req_ch | input | CH_W | Requested channel number |
| req_diff | input | 1 | 1 = differential pair, 0 = single-ended |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse, result valid |
| err | output | 1 | One-cycle pulse, channel out of range |
| rd_data | output | OUT_W | Aligned, extended sample |
| spi_cs_n | output | 1 | Converter chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Command data to converter |
| spi_miso | input | 1 | Sample data from converter |

## Verification
Some rules are checked by the bound checker on every cycle. SCLK is held low under a high CS, and CS is low only while busy. Done and err come only out of the right busy states. Every frame has the exact count of rising edges. The CS high gap is never shorter than one SCLK period. On single-input builds MOSI never rises. Command encodings, result alignment, sign extension, ignored requests and out-of-range errors depend on the data. Only the bench's scenarios show these, using a converter model that records the command byte and returns a chosen response word.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } rd_state_e;

    // Command bits clocked out before the response.
    function automatic int tx_bits_f(input int nch);
        return (nch > 1) ? 8 : 0;
    endfunction

    // Response length, whole bytes.
    function automatic int rx_bits_f(input int res);
        return ((res + 7) / 8) * 8;
    endfunction

endpackage

// File: rtl/sar_adc_tick.sv
module sar_adc_tick #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == CW'(HALF - 1));
        cnt_d = (!en || tick) ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sar_adc_cmd.sv
module sar_adc_cmd #(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3
) (
    input  logic [CH_W-1:0] ch,
    input  logic            diff,
    output logic [7:0]      cmd,
    output logic            ch_ok
);
    localparam int CHB = (NUM_CH > 1) ? $clog2(NUM_CH) : 0;

    generate
        if (NUM_CH >= (1 << CH_W)) begin : g_all_ok
            assign ch_ok = 1'b1;
        end else begin : g_range
            assign ch_ok = ((ch >> CHB) == '0);
        end

        if (NUM_CH == 1) begin : g_rx_only
            logic unused_sel;
            assign unused_sel = diff;
            assign cmd        = 8'h00;
        end else if (NUM_CH == 2) begin : g_two
            assign cmd = {3'b000, 1'b1, ~diff, ch[0], 2'b00};
        end else begin : g_wide
            assign cmd = 8'h40 | {2'b00, ~diff, 5'b00000} | (8'(ch) << 2);
        end
    endgenerate
endmodule

// File: rtl/sar_adc_align.sv
module sar_adc_align #(
    parameter int NUM_CH = 8,
    parameter int RES    = 12,
    parameter int RXB    = 16,
    parameter int OUT_W  = 16
) (
    input  logic [RXB-1:0]   word,
    output logic [OUT_W-1:0] value
);
    // Multi-input parts left-justify the sample in the response,
    // single-input parts end it three bits further down.
    localparam int SH   = (NUM_CH > 1) ? (RXB - RES) : (RXB - 3 - RES);
    localparam bit SGND = (RES == 13);

    logic [RXB-1:0] shifted;
    logic [RES-1:0] field;
    logic           unused_hi;

    assign shifted   = word >> SH;
    assign field     = shifted[RES-1:0];
    assign unused_hi = ^shifted;

    generate
        if (SGND) begin : g_signed
            assign value = OUT_W'($signed(field));
        end else begin : g_unsigned
            assign value = OUT_W'(field);
        end
    endgenerate
endmodule

// File: rtl/sar_adc_reader.sv
module sar_adc_reader
    import sar_adc_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int RES    = 12,
    parameter int OUT_W  = 16,
    parameter int CH_W   = 3,
    parameter int HALF   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [CH_W-1:0]  req_ch,
    input  logic             req_diff,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [OUT_W-1:0] rd_data,
    output logic             spi_cs_n,
    output logic             spi_sclk,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    localparam int TXB = tx_bits_f(NUM_CH);
    localparam int RXB = rx_bits_f(RES);
    localparam int TOT = TXB + RXB;
    localparam int BW  = $clog2(TOT);

    typedef struct packed {
        rd_state_e        st;
        logic             cs_n;
        logic             sclk;
        logic             busy;
        logic             done;
        logic             err;
        logic             gap;
        logic             in_rx;
        logic [BW-1:0]    bitn;
        logic [7:0]       tx;
        logic [RXB-1:0]   rx;
        logic [OUT_W-1:0] data;
    } regs_t;

    regs_t r_d, r_q;

    logic             tick;
    logic [7:0]       cmd_byte;
    logic             ch_ok;
    logic [OUT_W-1:0] aligned;

    sar_adc_tick #(.HALF(HALF)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (r_q.st != ST_IDLE),
        .tick (tick)
    );

    sar_adc_cmd #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_cmd (
        .ch   (req_ch),
        .diff (req_diff),
        .cmd  (cmd_byte),
        .ch_ok(ch_ok)
    );

    sar_adc_align #(.NUM_CH(NUM_CH), .RES(RES), .RXB(RXB), .OUT_W(OUT_W)) u_align (
        .word (r_q.rx),
        .value(aligned)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req) begin
                    if (ch_ok) begin
                        r_d.st    = ST_SHIFT;
                        r_d.cs_n  = 1'b0;
                        r_d.busy  = 1'b1;
                        r_d.bitn  = '0;
                        r_d.tx    = cmd_byte;
                        r_d.rx    = '0;
                        r_d.in_rx = (TXB == 0);
                    end else begin
                        r_d.err = 1'b1;
                    end
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (!r_q.sclk) begin
                        r_d.sclk = 1'b1;
                        if (r_q.in_rx) r_d.rx = {r_q.rx[RXB-2:0], spi_miso};
                    end else begin
                        r_d.sclk = 1'b0;
                        if (r_q.bitn == BW'(TXB - 1)) r_d.in_rx = 1'b1;
                        if (r_q.bitn == BW'(TOT - 1)) begin
                            r_d.st   = ST_GAP;
                            r_d.cs_n = 1'b1;
                            r_d.gap  = 1'b0;
                        end else begin
                            r_d.bitn = r_q.bitn + BW'(1);
                            r_d.tx   = {r_q.tx[6:0], 1'b0};
                        end
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (r_q.gap) begin
                        r_d.st   = ST_IDLE;
                        r_d.busy = 1'b0;
                        r_d.done = 1'b1;
                        r_d.data = aligned;
                    end else begin
                        r_d.gap = 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.cs_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = r_q.busy;
    assign done     = r_q.done;
    assign err      = r_q.err;
    assign rd_data  = r_q.data;
    assign spi_cs_n = r_q.cs_n;
    assign spi_sclk = r_q.sclk;
    assign spi_mosi = ~r_q.cs_n & ~r_q.in_rx & r_q.tx[7];
endmodule

// File: rtl/sar_adc_reader_chk.sv
module sar_adc_reader_chk
    import sar_adc_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int RES    = 12,
    parameter int HALF   = 2
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic err,
    input logic spi_cs_n,
    input logic spi_sclk,
    input logic spi_mosi
);
    localparam int TOT    = tx_bits_f(NUM_CH) + rx_bits_f(RES);
    localparam int GAPMIN = 2 * HALF;
    localparam int HW     = $clog2(GAPMIN + 1) + 1;

    logic          sclk_p;
    logic [7:0]    edge_cnt;
    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_p   <= 1'b0;
            edge_cnt <= '0;
            hi_cnt   <= HW'(GAPMIN);
        end else begin
            sclk_p <= spi_sclk;
            if (spi_cs_n)                  edge_cnt <= '0;
            else if (spi_sclk && !sclk_p)  edge_cnt <= edge_cnt + 8'd1;
            if (!spi_cs_n)                 hi_cnt <= '0;
            else if (hi_cnt < HW'(GAPMIN)) hi_cnt <= hi_cnt + HW'(1);
        end
    end

    assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    assert_frame_edges_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> (edge_cnt == 8'(TOT)));

    assert_cs_within_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> busy);

    assert_done_ends_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    assert_err_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && spi_cs_n && !done));

    assert_cs_gap_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> (hi_cnt >= HW'(GAPMIN)));

    generate
        if (NUM_CH == 1) begin : g_rx_only
            assert_mosi_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
                !spi_mosi);
        end else begin : g_tx
            assert_mosi_framed_R2: assert property (@(posedge clk) disable iff (!rst_n)
                spi_cs_n |-> !spi_mosi);
        end
    endgenerate
endmodule

bind sar_adc_reader sar_adc_reader_chk #(.NUM_CH(NUM_CH), .RES(RES), .HALF(HALF)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .err     (err),
    .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi)
);

// File: tb/sar_adc_reader_test.sv
`timescale 1ns/1ps

module sar_adc_model #(
    parameter int TXB = 8
) (
    input  logic        cs_n,
    input  logic        sclk,
    input  logic        mosi,
    input  logic [15:0] resp,
    output logic        miso,
    output logic [7:0]  cmd,
    output int          rises,
    output int          frames,
    output int          mosi_hi,
    output int          mosi_viol
);
    int fcnt;
    initial begin
        fcnt = 0; cmd = 0; rises = 0; frames = 0; mosi_hi = 0; mosi_viol = 0;
    end

    always @(negedge sclk or posedge cs_n) begin
        if (cs_n) fcnt = 0;
        else      fcnt = fcnt + 1;
    end

    always_comb begin
        int idx;
        idx  = fcnt - TXB;
        miso = (idx >= 0 && idx < 16) ? resp[15 - idx] : 1'b0;
    end

    always @(posedge sclk or negedge cs_n) begin
        if (!sclk) begin
            rises  = 0;
            cmd    = 0;
            frames = frames + 1;
        end else begin
            if (rises < TXB) cmd = {cmd[6:0], mosi};
            rises = rises + 1;
        end
    end

    always @(posedge mosi) mosi_hi = mosi_hi + 1;
    always @(mosi) if (sclk === 1'b1 && cs_n === 1'b0) mosi_viol = mosi_viol + 1;
endmodule

module sar_adc_reader_test;
    logic clk = 0;
    logic rst_n = 0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    // eight-input 12-bit reader
    logic m_req = 0, m_diff = 0; logic [2:0] m_ch = 0;
    logic m_busy, m_done, m_err, m_cs, m_sclk, m_mosi, m_miso;
    logic [15:0] m_rd, m_resp = 0;
    logic [7:0] m_cmd; int m_rises, m_frames, m_mhi, m_viol;

    // two-input 10-bit reader
    logic d_req = 0, d_diff = 0; logic [2:0] d_ch = 0;
    logic d_busy, d_done, d_err, d_cs, d_sclk, d_mosi, d_miso;
    logic [15:0] d_rd, d_resp = 0;
    logic [7:0] d_cmd; int d_rises, d_frames, d_mhi, d_viol;

    // single-input 13-bit reader
    logic s_req = 0, s_diff = 0; logic [2:0] s_ch = 0;
    logic s_busy, s_done, s_err, s_cs, s_sclk, s_mosi, s_miso;
    logic [15:0] s_rd, s_resp = 0;
    logic [7:0] s_cmd; int s_rises, s_frames, s_mhi, s_viol;

    sar_adc_reader #(.NUM_CH(8), .RES(12)) uut (
        .clk(clk), .rst_n(rst_n), .req(m_req), .req_ch(m_ch), .req_diff(m_diff),
        .busy(m_busy), .done(m_done), .err(m_err), .rd_data(m_rd),
        .spi_cs_n(m_cs), .spi_sclk(m_sclk), .spi_mosi(m_mosi), .spi_miso(m_miso));
    sar_adc_model #(.TXB(8)) m_adc (.cs_n(m_cs), .sclk(m_sclk), .mosi(m_mosi), .resp(m_resp),
        .miso(m_miso), .cmd(m_cmd), .rises(m_rises), .frames(m_frames),
        .mosi_hi(m_mhi), .mosi_viol(m_viol));

    sar_adc_reader #(.NUM_CH(2), .RES(10)) uut_d (
        .clk(clk), .rst_n(rst_n), .req(d_req), .req_ch(d_ch), .req_diff(d_diff),
        .busy(d_busy), .done(d_done), .err(d_err), .rd_data(d_rd),
        .spi_cs_n(d_cs), .spi_sclk(d_sclk), .spi_mosi(d_mosi), .spi_miso(d_miso));
    sar_adc_model #(.TXB(8)) d_adc (.cs_n(d_cs), .sclk(d_sclk), .mosi(d_mosi), .resp(d_resp),
        .miso(d_miso), .cmd(d_cmd), .rises(d_rises), .frames(d_frames),
        .mosi_hi(d_mhi), .mosi_viol(d_viol));

    sar_adc_reader #(.NUM_CH(1), .RES(13)) uut_s (
        .clk(clk), .rst_n(rst_n), .req(s_req), .req_ch(s_ch), .req_diff(s_diff),
        .busy(s_busy), .done(s_done), .err(s_err), .rd_data(s_rd),
        .spi_cs_n(s_cs), .spi_sclk(s_sclk), .spi_mosi(s_mosi), .spi_miso(s_miso));
    sar_adc_model #(.TXB(0)) s_adc (.cs_n(s_cs), .sclk(s_sclk), .mosi(s_mosi), .resp(s_resp),
        .miso(s_miso), .cmd(s_cmd), .rises(s_rises), .frames(s_frames),
        .mosi_hi(s_mhi), .mosi_viol(s_viol));

    // CS high-time monitor for uut
    int hi_run = 0, last_gap = 0;
    always @(negedge clk) begin
        if (m_cs) hi_run = hi_run + 1;
        else begin
            if (hi_run > 0) last_gap = hi_run;
            hi_run = 0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic xfer_m(input logic [2:0] ch, input logic dif, input logic [15:0] resp,
                          output logic [15:0] data);
        m_resp = resp;
        @(negedge clk); m_ch = ch; m_diff = dif; m_req = 1;
        @(negedge clk); m_req = 0;
        chk("R9 busy after request", m_busy, 1);
        while (!m_done) @(negedge clk);
        chk("R9 busy low with done", m_busy, 0);
        data = m_rd;
    endtask

    task automatic xfer_d(input logic [2:0] ch, input logic dif, input logic [15:0] resp,
                          output logic [15:0] data);
        d_resp = resp;
        @(negedge clk); d_ch = ch; d_diff = dif; d_req = 1;
        @(negedge clk); d_req = 0;
        while (!d_done) @(negedge clk);
        data = d_rd;
    endtask

    task automatic xfer_s(input logic dif, input logic [15:0] resp, output logic [15:0] data);
        s_resp = resp;
        @(negedge clk); s_ch = 0; s_diff = dif; s_req = 1;
        @(negedge clk); s_req = 0;
        while (!s_done) @(negedge clk);
        data = s_rd;
    endtask

    task automatic t_reset();
        chk("R1 cs_n", m_cs, 1);
        chk("R1 sclk", m_sclk, 0);
        chk("R1 mosi", m_mosi, 0);
        chk("R1 busy", m_busy, 0);
        chk("R1 done", m_done, 0);
        chk("R1 err", m_err, 0);
        chk("R1 rd_data", m_rd, 0);
    endtask

    task automatic t_wide();
        logic [15:0] v;
        xfer_m(3'd5, 1'b0, 16'hABCD, v);
        chk("R5 cmd ch5 single-ended", m_cmd, 8'h74);
        chk("R7 12-bit align", v, 16'h0ABC);
        chk("R3 rising edges", m_rises, 24);
        chk("R2 mosi stable while sclk high", m_viol, 0);
        @(negedge clk);
        chk("R9 done is one cycle", m_done, 0);
        xfer_m(3'd2, 1'b1, 16'h1234, v);
        chk("R5 cmd ch2 differential", m_cmd, 8'h48);
        chk("R7 12-bit align 2", v, 16'h0123);
        xfer_m(3'd7, 1'b0, 16'hFFFF, v);
        chk("R5 cmd ch7", m_cmd, 8'h7C);
        chk("R7 full scale", v, 16'h0FFF);
        xfer_m(3'd0, 1'b1, 16'h000F, v);
        chk("R5 cmd ch0 differential", m_cmd, 8'h40);
        chk("R7 low nibble dropped", v, 16'h0000);
        chk("R2 mosi stable across frames", m_viol, 0);
    endtask

    task automatic t_ignore();
        int f0, dones;
        f0 = m_frames; dones = 0;
        m_resp = 16'h5A5A;
        @(negedge clk); m_ch = 3'd1; m_diff = 0; m_req = 1;
        @(negedge clk); m_req = 0;
        repeat (20) @(negedge clk);
        m_ch = 3'd6; m_diff = 1; m_req = 1;
        @(negedge clk); m_req = 0;
        repeat (250) begin
            @(negedge clk);
            if (m_done) begin
                dones++;
                chk("R10 result of first request", m_rd, 16'h05A5);
                chk("R10 command of first request", m_cmd, 8'h64);
            end
        end
        chk("R10 single done", dones, 1);
        chk("R10 single frame", m_frames - f0, 1);
        chk("R10 idle afterwards", m_busy, 0);
    endtask

    task automatic t_gap();
        logic [15:0] v;
        xfer_m(3'd3, 1'b0, 16'h8001, v);
        xfer_m(3'd4, 1'b0, 16'h7FF0, v);
        chk("R7 back-to-back value", v, 16'h07FF);
        chk("R12 cs high gap", (last_gap >= 4), 1);
    endtask

    task automatic t_two();
        logic [15:0] v;
        int f0;
        xfer_d(3'd1, 1'b0, 16'hC3FF, v);
        chk("R4 cmd ch1 single-ended", d_cmd, 8'h1C);
        chk("R7 10-bit align", v, 16'h030F);
        xfer_d(3'd0, 1'b1, 16'h0040, v);
        chk("R4 cmd ch0 differential", d_cmd, 8'h10);
        chk("R7 10-bit lsb", v, 16'h0001);
        f0 = d_frames;
        @(negedge clk); d_ch = 3'd3; d_diff = 0; d_req = 1;
        @(negedge clk); d_req = 0;
        chk("R11 err pulse", d_err, 1);
        chk("R11 busy stays low", d_busy, 0);
        chk("R11 cs stays high", d_cs, 1);
        @(negedge clk);
        chk("R11 err one cycle", d_err, 0);
        repeat (20) @(negedge clk);
        chk("R11 no frame", d_frames - f0, 0);
    endtask

    task automatic t_single();
        logic [15:0] v0, v1;
        int f0;
        xfer_s(1'b0, 16'hF000, v0);
        chk("R8 negative full scale", v0, 16'hF000);
        chk("R3 receive-only edges", s_rises, 16);
        xfer_s(1'b1, 16'h1FFF, v0);
        chk("R8 minus one", v0, 16'hFFFF);
        xfer_s(1'b0, 16'hE0FF, v0);
        xfer_s(1'b1, 16'hE0FF, v1);
        chk("R8 top bits ignored", v0, 16'h00FF);
        chk("R6 diff flag no effect", v1, v0);
        chk("R6 mosi never high", s_mhi, 0);
        f0 = s_frames;
        @(negedge clk); s_ch = 3'd1; s_req = 1;
        @(negedge clk); s_req = 0;
        chk("R11 single-input err", s_err, 1);
        repeat (20) @(negedge clk);
        chk("R11 single-input no frame", s_frames - f0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_wide();
        t_ignore();
        t_gap();
        t_two();
        t_single();
        summary();
    end
endmodule